// File: doc/BRIEF.md
# Multi-Target Serial Peripheral Master

This block is a serial peripheral master that serves a parameterised number of targets over one shared clock, data-out and data-in wire set. Each target has its own select line. The master alone generates the serial clock. Each target owns a configuration word with these fields:

- clock idle level
- sampling phase
- select active level
- clock divider exponent
- word length

Software can rewrite any of these words at run time through a one-cycle write strobe.

A transfer starts with a one-cycle request that names the target and carries the transmit word. The block copies that target's settings for the length of the transfer. It shifts the word out most significant bit first while it shifts the incoming bits in. It then raises a one-cycle completion pulse and presents the received word. Busy stays high from acceptance until the pulse, and new requests are dropped during that time.

Top module: `spi_multi_master`

## Requirements
- R1: After reset, busy, done, sck, mosi and rx_word are 0. Every target's configuration is mode 0, active-low select, divider exponent 0 and the longest word length, so all select lines read 1.
- R2: A write with cfg_we=1 stores cfg_data into the word of target cfg_sel. The cfg_data layout is: bit 0 clock idle level, bit 1 phase, bit 2 select active level, bits [3 +: DIV_W] divider exponent, and the next LEN_W bits word length minus one. From the next cycle, an unselected target's select line is the inverse of its active level.
- R3: While busy, exactly the addressed target's select line sits at its active level, and every other line stays inactive.
- R4: From acceptance until the first edge, sck equals the target's idle level. A transfer of L bits makes exactly 2L sck edges, and sck ends at the idle level.
- R5: With phase 0, mosi carries the first bit before the first edge, the master samples miso on each leading edge, and mosi changes on trailing edges.
- R6: With phase 1, mosi changes on each leading edge and the master samples miso on each trailing edge.
- R7: An L-bit transfer sends the low L bits of tx_word, most significant first. rx_word returns the L received bits right-aligned with zero fill.
- R8: Each sck half period lasts 2^e clock cycles, where e is the divider exponent. Busy stays high for exactly 2^e*(2L+1) cycles.
- R9: done is a one-cycle pulse in the cycle busy falls. rx_word holds its value until the next done.
- R10: A start request seen while busy is ignored. It selects no other target and leaves the running transfer unchanged.
- R11: While busy, a write to the active target's word is dropped. A write to any other target takes effect at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W | Target whose word is written |
| cfg_data | input | CFG_W | Configuration word (layout in R2) |
| start | input | 1 | Transfer request |
| start_sel | input | SEL_W | Target of the request |
| tx_word | input | DATA_W | Transmit word, low bits used |
| miso | input | 1 | Serial data from targets |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_word | output | DATA_W | Received word, right-aligned |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to targets |
| ss_o | output | N_SLV | Per-target select lines |

## Verification
The bench models a target that reacts only to the sck edges it observes and uses the idle level and phase it was told about. This model separates the four clock modes, which a wrong leading/trailing classification would mix up. Random transmit and return words with random lengths from 1 to 16 bits, together with directed 1-bit and full-width words, tell a correct low-bit selection and right alignment apart from off-by-one shifts. Timed busy windows across all divider exponents tell the half-period length apart from the edge count. Mid-transfer requests and writes, aimed at both the active target and an idle one, separate a dropped action from an accepted one.

// File: rtl/spi_mm_pkg.sv
package spi_mm_pkg;
  // Bit positions inside a configuration word (visible to software)
  localparam int CPOL_B  = 0;
  localparam int CPHA_B  = 1;
  localparam int ACT_B   = 2;
  localparam int DIV_LSB = 3;

  function automatic int unsigned cfg_width(int unsigned div_w, int unsigned len_w);
    return DIV_LSB + div_w + len_w;
  endfunction

  function automatic int unsigned half_cycles(int unsigned e);
    return 32'd1 << e;
  endfunction
endpackage

// File: rtl/spi_cfg_bank.sv
module spi_cfg_bank import spi_mm_pkg::*; #(
  parameter int N_SLV = 4,
  parameter int SEL_W = 2,
  parameter int DIV_W = 2,
  parameter int LEN_W = 4,
  parameter int CFG_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] wsel,
  input  logic [CFG_W-1:0] wdata,
  input  logic             lock,
  input  logic [SEL_W-1:0] lock_sel,
  input  logic [SEL_W-1:0] rsel,
  output logic             rd_cpol,
  output logic             rd_cpha,
  output logic [DIV_W-1:0] rd_div,
  output logic [LEN_W-1:0] rd_len_m1,
  output logic [N_SLV-1:0] act_all
);
  localparam logic [CFG_W-1:0] RST_VAL = CFG_W'({{LEN_W{1'b1}}, {(DIV_LSB + DIV_W){1'b0}}});

  logic [CFG_W-1:0] regs [N_SLV];
  logic [CFG_W-1:0] rd;

  for (genvar i = 0; i < N_SLV; i++) begin : g_slv
    logic [CFG_W-1:0] word_q;
    logic             wr_hit;
    assign wr_hit = we && (wsel == SEL_W'(i)) && !(lock && (lock_sel == SEL_W'(i)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      word_q <= RST_VAL;
      else if (wr_hit) word_q <= wdata;
    end
    assign regs[i]    = word_q;
    assign act_all[i] = word_q[ACT_B];
  end

  assign rd        = regs[rsel];
  assign rd_cpol   = rd[CPOL_B];
  assign rd_cpha   = rd[CPHA_B];
  assign rd_div    = rd[DIV_LSB +: DIV_W];
  assign rd_len_m1 = rd[DIV_LSB + DIV_W +: LEN_W];
endmodule

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int DIV_W = 2,
  parameter int TMR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [DIV_W-1:0] exp_sel,
  output logic             tick
);
  logic [TMR_W-1:0] cnt_q;
  logic [TMR_W-1:0] reload;

  assign reload = TMR_W'(spi_mm_pkg::half_cycles(32'(exp_sel)) - 1);
  assign tick   = run && !load && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (load || tick)      cnt_q <= reload;
    else if (run)               cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] tx_word,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic              cpha,
  input  logic              drive,
  input  logic              sample,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_bits
);
  // Move the low (len_m1+1) bits to the top so the MSB leaves first
  function automatic logic [DATA_W-1:0] align_left(logic [DATA_W-1:0] w, logic [LEN_W-1:0] lm1);
    return w << (LEN_W'(DATA_W - 1) - lm1);
  endfunction

  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] tx_aligned;

  assign tx_aligned = align_left(tx_word, len_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh   <= '0;
      rx_bits <= '0;
      mosi    <= 1'b0;
    end else if (load) begin
      rx_bits <= '0;
      if (cpha) begin
        tx_sh <= tx_aligned;
        mosi  <= 1'b0;
      end else begin
        tx_sh <= tx_aligned << 1;
        mosi  <= tx_aligned[DATA_W-1];
      end
    end else begin
      if (drive) begin
        mosi  <= tx_sh[DATA_W-1];
        tx_sh <= tx_sh << 1;
      end
      if (sample) rx_bits <= {rx_bits[DATA_W-2:0], miso};
    end
  end
endmodule

// File: rtl/spi_multi_master.sv
module spi_multi_master import spi_mm_pkg::*; #(
  parameter  int N_SLV  = 4,
  parameter  int DIV_W  = 2,
  parameter  int LEN_W  = 4,
  localparam int SEL_W  = (N_SLV > 1) ? $clog2(N_SLV) : 1,
  localparam int DATA_W = 1 << LEN_W,
  localparam int CFG_W  = cfg_width(DIV_W, LEN_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [CFG_W-1:0]  cfg_data,
  input  logic              start,
  input  logic [SEL_W-1:0]  start_sel,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_word,
  output logic              sck,
  output logic              mosi,
  output logic [N_SLV-1:0]  ss_o
);
  localparam int ECNT_W = LEN_W + 2;
  localparam int TMR_W  = (1 << DIV_W) - 1;

  logic              busy_q, done_q, sck_q;
  logic [SEL_W-1:0]  cur_sel_q;
  logic              cur_cpol_q, cur_cpha_q;
  logic [DIV_W-1:0]  cur_div_q;
  logic [LEN_W-1:0]  cur_len_q;
  logic [ECNT_W-1:0] edge_q;
  logic [DATA_W-1:0] rx_q;

  // Named internal events
  logic              accept, tick, last_slot, lead_edge, trail_edge, drive_ev, sample_ev;
  logic              sel_cpol, sel_cpha;
  logic [DIV_W-1:0]  sel_div, tmr_exp;
  logic [LEN_W-1:0]  sel_len, sh_len;
  logic [N_SLV-1:0]  act_all;
  logic [DATA_W-1:0] sh_rx;

  assign accept     = start && !busy_q;
  assign last_slot  = edge_q == ECNT_W'({1'b0, cur_len_q, 1'b0}) + ECNT_W'(2);
  assign lead_edge  = tick && !last_slot && (sck_q == cur_cpol_q);
  assign trail_edge = tick && !last_slot && (sck_q != cur_cpol_q);
  assign drive_ev   = cur_cpha_q ? lead_edge  : trail_edge;
  assign sample_ev  = cur_cpha_q ? trail_edge : lead_edge;
  assign tmr_exp    = accept ? sel_div : cur_div_q;
  assign sh_len     = sel_len;

  spi_cfg_bank #(.N_SLV(N_SLV), .SEL_W(SEL_W), .DIV_W(DIV_W), .LEN_W(LEN_W), .CFG_W(CFG_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wsel(cfg_sel), .wdata(cfg_data),
    .lock(busy_q), .lock_sel(cur_sel_q), .rsel(start_sel),
    .rd_cpol(sel_cpol), .rd_cpha(sel_cpha), .rd_div(sel_div), .rd_len_m1(sel_len),
    .act_all(act_all)
  );

  spi_half_timer #(.DIV_W(DIV_W), .TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(accept), .run(busy_q), .exp_sel(tmr_exp), .tick(tick)
  );

  spi_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .load(accept), .tx_word(tx_word), .len_m1(sh_len),
    .cpha(sel_cpha), .drive(drive_ev), .sample(sample_ev), .miso(miso),
    .mosi(mosi), .rx_bits(sh_rx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; done_q <= 1'b0; sck_q <= 1'b0;
      cur_sel_q <= '0; cur_cpol_q <= 1'b0; cur_cpha_q <= 1'b0;
      cur_div_q <= '0; cur_len_q <= '0; edge_q <= '0; rx_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q     <= 1'b1;
        cur_sel_q  <= start_sel;
        cur_cpol_q <= sel_cpol;
        cur_cpha_q <= sel_cpha;
        cur_div_q  <= sel_div;
        cur_len_q  <= sel_len;
        edge_q     <= '0;
        sck_q      <= sel_cpol;
      end else if (tick) begin
        if (last_slot) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          rx_q   <= sh_rx;
        end else begin
          sck_q  <= ~sck_q;
          edge_q <= edge_q + 1'b1;
        end
      end
    end
  end

  for (genvar i = 0; i < N_SLV; i++) begin : g_ss
    assign ss_o[i] = (busy_q && cur_sel_q == SEL_W'(i)) ? act_all[i] : ~act_all[i];
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign sck     = sck_q;
  assign rx_word = rx_q;
endmodule

// File: rtl/spi_mm_checker.sv
module spi_mm_checker #(
  parameter int N_SLV = 4,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             accept,
  input logic             tick,
  input logic             sck,
  input logic [N_SLV-1:0] ss,
  input logic [N_SLV-1:0] act_all,
  input logic [SEL_W-1:0] cur_sel
);
  a_r3_one_selected: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $countones(ss ^ ~act_all) == 1);

  a_r2_idle_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ss == ~act_all);

  a_r9_done_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_target_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(cur_sel)));

  a_r4_sck_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(sck));

  a_r4_sck_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !accept) |=> $stable(sck));
endmodule

bind spi_multi_master spi_mm_checker #(.N_SLV(N_SLV), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_q), .done(done_q), .accept(accept),
  .tick(tick), .sck(sck_q), .ss(ss_o), .act_all(act_all), .cur_sel(cur_sel_q)
);

// File: tb/sim_spi_multi_master.sv
`timescale 1ns/1ps
module sim_spi_multi_master;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 1'b0, start = 1'b0, miso = 1'b0;
  logic [1:0]  cfg_sel = '0, start_sel = '0;
  logic [8:0]  cfg_data = '0;
  logic [15:0] tx_word = '0;
  logic        busy, done, sck, mosi;
  logic [15:0] rx_word;
  logic [3:0]  ss_o;

  spi_multi_master u0 (.*);

  always #2.5 clk = ~clk;

  int n_chk = 0, n_err = 0, n_done = 0;
  bit b_cpol [4], b_cpha [4], b_act [4];
  int b_div [4], b_lm1 [4];

  // target model state
  bit m_cpol, m_cpha, m_busy_prev, m_sck_prev;
  int m_oidx, m_edges;
  logic [15:0] m_miso_word, m_cap;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] pack_cfg(bit cpol, bit cpha, bit act, int dv, int lm1);
    return {4'(lm1), 2'(dv), act, cpha, cpol};
  endfunction

  function automatic logic [3:0] exp_ss(bit active, int sel);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = (active && i == sel) ? b_act[i] : !b_act[i];
    return r;
  endfunction

  function automatic logic [15:0] low_mask(int len);
    return 16'((32'd1 << len) - 1);
  endfunction

  task automatic model_drive();
    miso = (m_oidx >= 0) ? m_miso_word[m_oidx] : 1'b0;
    m_oidx--;
  endtask

  always @(negedge clk) begin
    if (busy && m_busy_prev && sck != m_sck_prev) begin
      m_edges++;
      if (sck != m_cpol) begin
        if (!m_cpha) m_cap = {m_cap[14:0], mosi}; else model_drive();
      end else begin
        if (!m_cpha) model_drive(); else m_cap = {m_cap[14:0], mosi};
      end
    end
    m_sck_prev  = sck;
    m_busy_prev = busy;
    if (done) n_done++;
  end

  task automatic wr_cfg(int sel, bit cpol, bit cpha, bit act, int dv, int lm1);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_data = pack_cfg(cpol, cpha, act, dv, lm1);
    @(negedge clk);
    cfg_we = 1'b0;
    b_cpol[sel] = cpol; b_cpha[sel] = cpha; b_act[sel] = act; b_div[sel] = dv; b_lm1[sel] = lm1;
    check(ss_o == exp_ss(0, 0), "R2 idle select levels", ss_o, exp_ss(0, 0));
  endtask

  // inject: 0 none, 1 start to another target, 2 write active target, 3 write another target
  task automatic xfer(int sel, logic [15:0] tx, logic [15:0] mw, int inject);
    int len, h, cycles, other, d0;
    len = b_lm1[sel] + 1; h = 1 << b_div[sel]; other = (sel + 1) % 4;
    m_cpol = b_cpol[sel]; m_cpha = b_cpha[sel]; m_miso_word = mw;
    m_cap = '0; m_edges = 0; d0 = n_done;
    m_oidx = m_cpha ? len - 1 : len - 2;
    miso = m_cpha ? 1'b0 : mw[len-1];
    @(negedge clk);
    start = 1'b1; start_sel = 2'(sel); tx_word = tx;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R8 busy after accept", busy, 1);
    check(ss_o == exp_ss(1, sel), "R3 select during transfer", ss_o, exp_ss(1, sel));
    check(sck == m_cpol, "R4 sck idle before first edge", sck, m_cpol);
    if (!m_cpha) check(mosi == tx[len-1], "R5 first bit before first edge", mosi, tx[len-1]);
    cycles = 1;
    while (cycles < 5000) begin
      @(negedge clk);
      if (cycles == 3) begin
        if (inject == 1) begin
          start = 1'b0;
          check(ss_o == exp_ss(busy, sel), "R10 start while busy ignored", ss_o, exp_ss(busy, sel));
        end
        if (inject == 2 || inject == 3) cfg_we = 1'b0;
        if (inject == 3)
          check(ss_o == exp_ss(busy, sel), "R11 write to other target applied", ss_o, exp_ss(busy, sel));
      end
      if (!busy) break;
      cycles++;
      if (cycles == 3) begin
        if (inject == 1) begin
          start = 1'b1; start_sel = 2'(other); tx_word = ~tx;
        end
        if (inject == 2) begin
          cfg_we = 1'b1; cfg_sel = 2'(sel);
          cfg_data = pack_cfg(!b_cpol[sel], b_cpha[sel], b_act[sel], b_div[sel], (b_lm1[sel] + 5) % 16);
        end
        if (inject == 3) begin
          cfg_we = 1'b1; cfg_sel = 2'(other);
          cfg_data = pack_cfg(b_cpol[other], b_cpha[other], !b_act[other], b_div[other], b_lm1[other]);
          b_act[other] = !b_act[other];
        end
      end
    end
    start = 1'b0; cfg_we = 1'b0;
    check(done == 1'b1, "R9 done as busy falls", done, 1);
    check(cycles == h * (2 * len + 1), "R8 busy length", cycles, h * (2 * len + 1));
    check(m_edges == 2 * len, "R4 edge count", m_edges, 2 * len);
    check(sck == m_cpol, "R4 sck back at idle", sck, m_cpol);
    check(rx_word == (mw & low_mask(len)), m_cpha ? "R6 R7 received word" : "R5 R7 received word",
          rx_word, mw & low_mask(len));
    check(m_cap == (tx & low_mask(len)), m_cpha ? "R6 R7 sent bits" : "R5 R7 sent bits",
          m_cap, tx & low_mask(len));
    check(ss_o == exp_ss(0, 0), "R3 select released", ss_o, exp_ss(0, 0));
    @(negedge clk);
    check(done == 1'b0, "R9 done single cycle", done, 0);
    check(n_done - d0 == 1, "R9 R10 one completion", n_done - d0, 1);
    check(rx_word == (mw & low_mask(len)), "R9 rx_word held", rx_word, mw & low_mask(len));
  endtask

  initial begin
    #1000000;
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int r;
    r = $urandom(32'h1F2E);
    for (int i = 0; i < 4; i++) begin
      b_cpol[i] = 0; b_cpha[i] = 0; b_act[i] = 0; b_div[i] = 0; b_lm1[i] = 15;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    check({busy, done, sck, mosi} == 4'b0, "R1 reset controls", {busy, done, sck, mosi}, 0);
    check(rx_word == 16'h0, "R1 reset rx_word", rx_word, 0);
    check(ss_o == 4'b1111, "R1 reset selects", ss_o, 4'hF);
    rst_n = 1'b1;
    @(negedge clk);
    check(ss_o == 4'b1111, "R1 selects after release", ss_o, 4'hF);
    // R1 defaults: mode 0, div 0, 16 bits
    xfer(0, 16'hA5C3, 16'h3C5A, 0);
    // directed: four modes, shortest and longest words
    wr_cfg(1, 0, 1, 1, 0, 0);  xfer(1, 16'h0001, 16'h0001, 0);
    wr_cfg(2, 1, 0, 0, 1, 15); xfer(2, 16'h8001, 16'hFFFE, 0);
    wr_cfg(3, 1, 1, 1, 3, 7);  xfer(3, 16'hFF96, 16'h00E7, 0);
    wr_cfg(0, 0, 1, 0, 2, 3);  xfer(0, 16'h123B, 16'hFFF4, 0);
    // R10 start while busy, R11 writes while busy
    xfer(2, 16'h4D2C, 16'h9B17, 1);
    xfer(1, 16'h0000, 16'h0001, 2);
    xfer(1, 16'h0001, 16'h0000, 0);  // old length still in force (R11)
    xfer(3, 16'h5A5A, 16'hC0DE, 3);
    xfer(0, 16'h7777, 16'h1234, 0);  // target 0 now active-high (R11)
    // random mix
    for (int k = 0; k < 30; k++) begin
      int s;
      s = $urandom_range(3);
      wr_cfg(s, 1'($urandom), 1'($urandom), 1'($urandom), $urandom_range(3), $urandom_range(15));
      xfer($urandom_range(3), 16'($urandom), 16'($urandom), 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule